// File: doc/BRIEF.md
# Pre-Decrement Memory Store Sequencer

This block carries out one two-byte store instruction. A byte held in a working register is written to memory at a 16-bit address taken from a working register pair. The pair is decremented by one before the access, and the new value is written back to the register file. The first instruction byte must be the opcode F2h. The second byte names the source register and the pointer pair. The lowest bit of the pointer field selects the target memory space.

The fetch logic presents both instruction bytes with a one-cycle `start` pulse. The sequencer then reads the register file through a single read port that returns data in the same cycle, and writes to it through a single write port. It issues exactly one memory write and signals completion with `done` fourteen cycles after the start. No flags or other registers are touched. A start that arrives while an instruction is in flight is dropped.

Top module: `predec_store_seq`

## Requirements
- R1: While reset is held and in the first cycle after it, `busy`, `done`, `mem_we` and `rf_we` are all low.
- R2: A start pulse is accepted only when `op_byte` equals F2h and the block is idle. With any other opcode, none of `busy`, `mem_we`, `rf_we` or `done` rises.
- R3: In `arg_byte`, bits 7:4 name the source register and bits 3:0 are the pointer field. The pair is the pointer field with bit 0 cleared. Its high byte lives in the even register and its low byte in the odd register (even + 1).
- R4: The memory address is the 16-bit pair value minus one, with the borrow carried from the low byte into the high byte (3000h gives 2FFFh).
- R5: A pair value of 0000h wraps to the address FFFFh.
- R6: `mem_space` is 0 (program memory) when pointer field bit 0 is 0, and 1 (external data memory) when it is 1.
- R7: `mem_we` is high for exactly one cycle per instruction, 9 cycles after the accepting edge. `mem_wdata` equals the source register's value at start, and address and data are held unchanged from the cycle before.
- R8: The decremented low byte is written to the odd register and then the high byte to the even register, in the two cycles after the memory write. No other register is written, so a source outside the pair keeps its value.
- R9: `done` is a single-cycle pulse, high in the 13th cycle after the accepting clock edge (the 14th cycle counting the start cycle).
- R10: A start pulse that arrives while `busy` is high is ignored: the running instruction's timing, address, data and space are unchanged.
- R11: `busy` is high from the accepting edge through the `done` cycle, and low in the cycle after.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| start | input | 1 | One-cycle request to execute the presented instruction |
| op_byte | input | 8 | First instruction byte (opcode) |
| arg_byte | input | 8 | Second instruction byte: source register and pointer field |
| rf_raddr | output | 4 | Register file read address |
| rf_rdata | input | 8 | Register file read data, same-cycle |
| rf_we | output | 1 | Register file write enable |
| rf_waddr | output | 4 | Register file write address |
| rf_wdata | output | 8 | Register file write data |
| mem_we | output | 1 | Memory write strobe |
| mem_space | output | 1 | 0 = program memory, 1 = external data memory |
| mem_addr | output | 16 | Memory address |
| mem_wdata | output | 8 | Memory write data |
| busy | output | 1 | Instruction in progress |
| done | output | 1 | Completion pulse |

## Verification
On every cycle, the embedded assertions check the following properties. The memory strobe is a one-cycle pulse with a steady address and data. The idle block stays silent on both write ports. Register writes occur only while busy. `done` ends the busy period. The space select cannot change in mid-instruction. The borrow chain of the decrementer is also checked for its wrap. Some behaviours only the bench's scenarios can show: the exact cycle of each event, the decremented address including the 0000h wrap, the written-back bytes, and that dropped starts (wrong opcode, or a start while busy) really leave no trace. The bench compares the outputs against a behavioural model on every clock.

// File: rtl/pds_pkg.sv
package pds_pkg;

    typedef enum logic [3:0] {
        ACT_NONE,
        ACT_RD_LO,
        ACT_RD_HI,
        ACT_CALC,
        ACT_RD_SRC,
        ACT_MEM_WR,
        ACT_WB_LO,
        ACT_WB_HI,
        ACT_DONE
    } pds_act_e;

endpackage

// File: rtl/pds_decode.sv
module pds_decode #(
    parameter int          OPC_W  = 8,
    parameter int          RF_AW  = 4,
    parameter logic [7:0]  OPCODE = 8'hF2
) (
    input  logic [OPC_W-1:0]   op_i,
    input  logic [2*RF_AW-1:0] arg_i,
    output logic               match_o,
    output logic [RF_AW-1:0]   src_o,
    output logic [RF_AW-1:0]   pair_o,
    output logic               space_o
);
    localparam int ARG_W = 2 * RF_AW;

    always_comb begin
        match_o = (op_i == OPC_W'(OPCODE));
        src_o   = arg_i[ARG_W-1:RF_AW];
        pair_o  = {arg_i[RF_AW-1:1], 1'b0};
        space_o = arg_i[0];
    end

endmodule

// File: rtl/pds_decrement.sv
module pds_decrement #(
    parameter int W = 16
) (
    input  logic [W-1:0] val_i,
    output logic [W-1:0] dec_o
);
    logic [W:0] borrow;

    assign borrow[0] = 1'b1;

    for (genvar i = 0; i < W; i++) begin : g_bit
        assign dec_o[i]    = val_i[i] ^ borrow[i];
        assign borrow[i+1] = borrow[i] & ~val_i[i];
    end

    always_comb begin
        AST_DEC_BORROW: assert (W'(dec_o + 1'b1) == val_i); // R4, R5
    end

endmodule

// File: rtl/pds_phase.sv
module pds_phase #(
    parameter int STEP_W    = 4,
    parameter int MEM_STEP  = 9,
    parameter int DONE_STEP = 13
) (
    input  logic [STEP_W-1:0]   step_i,
    output pds_pkg::pds_act_e   act_o
);
    import pds_pkg::*;

    localparam int RD_LO_STEP  = 1;
    localparam int RD_HI_STEP  = 2;
    localparam int CALC_STEP   = 3;
    localparam int RD_SRC_STEP = 4;
    localparam int WB_LO_STEP  = MEM_STEP + 1;
    localparam int WB_HI_STEP  = MEM_STEP + 2;

    always_comb begin
        act_o = ACT_NONE;
        if (step_i == STEP_W'(RD_LO_STEP))       act_o = ACT_RD_LO;
        else if (step_i == STEP_W'(RD_HI_STEP))  act_o = ACT_RD_HI;
        else if (step_i == STEP_W'(CALC_STEP))   act_o = ACT_CALC;
        else if (step_i == STEP_W'(RD_SRC_STEP)) act_o = ACT_RD_SRC;
        else if (step_i == STEP_W'(MEM_STEP))    act_o = ACT_MEM_WR;
        else if (step_i == STEP_W'(WB_LO_STEP))  act_o = ACT_WB_LO;
        else if (step_i == STEP_W'(WB_HI_STEP))  act_o = ACT_WB_HI;
        else if (step_i == STEP_W'(DONE_STEP))   act_o = ACT_DONE;
    end

endmodule

// File: rtl/predec_store_seq.sv
module predec_store_seq #(
    parameter int         DATA_W    = 8,
    parameter int         RF_AW     = 4,
    parameter logic [7:0] OPCODE    = 8'hF2,
    parameter int         TOTAL_CYC = 14,
    parameter int         MEM_STEP  = 9
) (
    input  logic                clk,
    input  logic                rst_n,
    input  logic                start,
    input  logic [7:0]          op_byte,
    input  logic [2*RF_AW-1:0]  arg_byte,
    output logic [RF_AW-1:0]    rf_raddr,
    input  logic [DATA_W-1:0]   rf_rdata,
    output logic                rf_we,
    output logic [RF_AW-1:0]    rf_waddr,
    output logic [DATA_W-1:0]   rf_wdata,
    output logic                mem_we,
    output logic                mem_space,
    output logic [2*DATA_W-1:0] mem_addr,
    output logic [DATA_W-1:0]   mem_wdata,
    output logic                busy,
    output logic                done
);
    import pds_pkg::*;

    localparam int ADDR_W    = 2 * DATA_W;
    localparam int DONE_STEP = TOTAL_CYC - 1;
    localparam int STEP_W    = $clog2(TOTAL_CYC);

    typedef struct packed {
        logic              busy;
        logic [STEP_W-1:0] step;
        logic [RF_AW-1:0]  src;
        logic [RF_AW-1:0]  pair;
        logic              space;
        logic [DATA_W-1:0] hi;
        logic [DATA_W-1:0] lo;
        logic [ADDR_W-1:0] ptr;
        logic [DATA_W-1:0] data;
    } seq_state_t;

    seq_state_t st_q, st_d;

    logic              dec_match;
    logic [RF_AW-1:0]  dec_src;
    logic [RF_AW-1:0]  dec_pair;
    logic              dec_space;
    logic [ADDR_W-1:0] ptr_dec;
    pds_act_e          act;
    logic [RF_AW-1:0]  pair_odd;

    pds_decode #(
        .OPC_W  (8),
        .RF_AW  (RF_AW),
        .OPCODE (OPCODE)
    ) i_decode (
        .op_i    (op_byte),
        .arg_i   (arg_byte),
        .match_o (dec_match),
        .src_o   (dec_src),
        .pair_o  (dec_pair),
        .space_o (dec_space)
    );

    pds_decrement #(
        .W (ADDR_W)
    ) i_decrement (
        .val_i ({st_q.hi, st_q.lo}),
        .dec_o (ptr_dec)
    );

    pds_phase #(
        .STEP_W    (STEP_W),
        .MEM_STEP  (MEM_STEP),
        .DONE_STEP (DONE_STEP)
    ) i_phase (
        .step_i (st_q.step),
        .act_o  (act)
    );

    assign pair_odd = {st_q.pair[RF_AW-1:1], 1'b1};

    always_comb begin
        st_d     = st_q;
        rf_raddr = st_q.src;
        rf_we    = 1'b0;
        rf_waddr = st_q.pair;
        rf_wdata = st_q.ptr[DATA_W-1:0];
        mem_we   = 1'b0;
        done     = 1'b0;

        if (!st_q.busy) begin
            if (start && dec_match) begin
                st_d.busy  = 1'b1;
                st_d.step  = STEP_W'(1);
                st_d.src   = dec_src;
                st_d.pair  = dec_pair;
                st_d.space = dec_space;
            end
        end else begin
            st_d.step = st_q.step + 1'b1;
            case (act)
                ACT_RD_LO: begin
                    rf_raddr = pair_odd;
                    st_d.lo  = rf_rdata;
                end
                ACT_RD_HI: begin
                    rf_raddr = st_q.pair;
                    st_d.hi  = rf_rdata;
                end
                ACT_CALC: begin
                    st_d.ptr = ptr_dec;
                end
                ACT_RD_SRC: begin
                    rf_raddr  = st_q.src;
                    st_d.data = rf_rdata;
                end
                ACT_MEM_WR: begin
                    mem_we = 1'b1;
                end
                ACT_WB_LO: begin
                    rf_we    = 1'b1;
                    rf_waddr = pair_odd;
                    rf_wdata = st_q.ptr[DATA_W-1:0];
                end
                ACT_WB_HI: begin
                    rf_we    = 1'b1;
                    rf_waddr = st_q.pair;
                    rf_wdata = st_q.ptr[ADDR_W-1:DATA_W];
                end
                ACT_DONE: begin
                    done      = 1'b1;
                    st_d.busy = 1'b0;
                    st_d.step = '0;
                end
                default: ;
            endcase
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            st_q <= '0;
        end else begin
            st_q <= st_d;
        end
    end

    assign mem_addr  = st_q.ptr;
    assign mem_wdata = st_q.data;
    assign mem_space = st_q.space;
    assign busy      = st_q.busy;

    AST_WE_PULSE: assert property (@(posedge clk) disable iff (!rst_n)
        mem_we |=> !mem_we); // R7
    AST_MEM_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
        mem_we |-> ($stable(mem_addr) && $stable(mem_wdata))); // R7
    AST_DONE_ENDS: assert property (@(posedge clk) disable iff (!rst_n)
        done |=> (!done && !busy)); // R9
    AST_IDLE_QUIET: assert property (@(posedge clk) disable iff (!rst_n)
        !busy |-> (!mem_we && !rf_we && !done)); // R2
    AST_WB_AFTER_MEM: assert property (@(posedge clk) disable iff (!rst_n)
        rf_we |-> (busy && !mem_we && !done)); // R8
    AST_HOLD_IN_FLIGHT: assert property (@(posedge clk) disable iff (!rst_n)
        (busy && !done) |=> (busy && $stable(mem_space))); // R10

endmodule

// File: tb/test_predec_store_seq.sv
module test_predec_store_seq;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        start = 1'b0;
    logic [7:0]  op_byte = 8'h00;
    logic [7:0]  arg_byte = 8'h00;
    logic [3:0]  rf_raddr;
    logic [7:0]  rf_rdata;
    logic        rf_we;
    logic [3:0]  rf_waddr;
    logic [7:0]  rf_wdata;
    logic        mem_we;
    logic        mem_space;
    logic [15:0] mem_addr;
    logic [7:0]  mem_wdata;
    logic        busy;
    logic        done;

    logic [7:0]  rf [16];
    logic        tb_we = 1'b0;
    logic [3:0]  tb_waddr = 4'h0;
    logic [7:0]  tb_wdata = 8'h00;

    int tests = 0;
    int fails = 0;

    int cyc = 0;
    int t0 = 0;
    bit m_act = 1'b0;
    int e_addr, e_data, e_space, e_pair, e_src, e_srcval;

    always #5 clk = ~clk;

    predec_store_seq i_predec_store_seq (
        .clk       (clk),
        .rst_n     (rst_n),
        .start     (start),
        .op_byte   (op_byte),
        .arg_byte  (arg_byte),
        .rf_raddr  (rf_raddr),
        .rf_rdata  (rf_rdata),
        .rf_we     (rf_we),
        .rf_waddr  (rf_waddr),
        .rf_wdata  (rf_wdata),
        .mem_we    (mem_we),
        .mem_space (mem_space),
        .mem_addr  (mem_addr),
        .mem_wdata (mem_wdata),
        .busy      (busy),
        .done      (done)
    );

    assign rf_rdata = rf[rf_raddr];

    always @(posedge clk) begin
        if (rf_we) rf[rf_waddr] <= rf_wdata;
        else if (tb_we) rf[tb_waddr] <= tb_wdata;
    end

    task automatic chk(input bit ok, input string req, input int act, input int exp);
        tests++;
        if (!ok) begin
            fails++;
            $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
        end
    endtask

    // behavioural reference: records the accepting edge and the values read from the bench's register model
    always @(posedge clk) begin
        if (!rst_n) begin
            cyc = 0;
            m_act = 1'b0;
        end else begin
            if (start && op_byte == 8'hF2 && !(m_act && cyc <= t0 + 12)) begin
                t0       = cyc + 1;
                m_act    = 1'b1;
                e_pair   = int'(arg_byte[3:0]) & 14;
                e_src    = int'(arg_byte[7:4]);
                e_space  = int'(arg_byte[0]);
                e_addr   = ((int'(rf[e_pair]) * 256 + int'(rf[e_pair + 1])) + 65535) % 65536;
                e_data   = int'(rf[e_src]);
                e_srcval = e_data;
            end
            cyc = cyc + 1;
        end
    end

    always @(negedge clk) begin
        if (rst_n) begin
            int p;
            bit in_run;
            p = cyc - t0;
            in_run = m_act && p >= 0 && p <= 12;
            chk(busy == in_run, "R11 busy", busy, in_run);
            chk(done == (in_run && p == 12), "R9 done", done, in_run && p == 12);
            chk(mem_we == (in_run && p == 8), "R7 mem_we", mem_we, in_run && p == 8);
            chk(rf_we == (in_run && (p == 9 || p == 10)), "R8 rf_we", rf_we, in_run && (p == 9 || p == 10));
            if (in_run && p == 8) begin
                chk(int'(mem_addr) == e_addr, "R4 R5 mem_addr", mem_addr, e_addr);
                chk(int'(mem_wdata) == e_data, "R7 mem_wdata", mem_wdata, e_data);
                chk(int'(mem_space) == e_space, "R6 mem_space", mem_space, e_space);
            end
            if (in_run && p == 9) begin
                chk(int'(rf_waddr) == e_pair + 1, "R3 low byte reg", rf_waddr, e_pair + 1);
                chk(int'(rf_wdata) == (e_addr % 256), "R8 low byte", rf_wdata, e_addr % 256);
            end
            if (in_run && p == 10) begin
                chk(int'(rf_waddr) == e_pair, "R3 high byte reg", rf_waddr, e_pair);
                chk(int'(rf_wdata) == (e_addr / 256), "R8 high byte", rf_wdata, e_addr / 256);
            end
            if (in_run && p == 12 && e_src != e_pair && e_src != e_pair + 1)
                chk(int'(rf[e_src]) == e_srcval, "R8 source kept", rf[e_src], e_srcval);
        end
    end

    task automatic poke(input logic [3:0] a, input logic [7:0] v);
        @(negedge clk);
        tb_we = 1'b1;
        tb_waddr = a;
        tb_wdata = v;
        @(negedge clk);
        tb_we = 1'b0;
    endtask

    task automatic issue(input logic [7:0] op, input logic [7:0] arg);
        @(negedge clk);
        start = 1'b1;
        op_byte = op;
        arg_byte = arg;
        @(negedge clk);
        start = 1'b0;
    endtask

    task automatic idle(input int n);
        repeat (n) @(negedge clk);
    endtask

    initial begin
        for (int i = 0; i < 16; i++) rf[i] = 8'h00;
        repeat (3) @(negedge clk);
        // R1: outputs quiet under reset
        chk(!busy && !done && !mem_we && !rf_we, "R1 reset state",
            {busy, done, mem_we, rf_we}, 0);
        rst_n = 1'b1;
        @(negedge clk);
        chk(!busy && !done && !mem_we && !rf_we, "R1 after reset",
            {busy, done, mem_we, rf_we}, 0);

        // R4 R6: even field, program memory, borrow across the byte
        poke(4'h0, 8'h77);
        poke(4'h6, 8'h30);
        poke(4'h7, 8'h00);
        issue(8'hF2, 8'h06);
        idle(16);
        chk(rf[6] == 8'h2F && rf[7] == 8'hFF, "R4 pair after", {rf[6], rf[7]}, 16'h2FFF);
        chk(rf[0] == 8'h77, "R8 source unchanged", rf[0], 8'h77);

        // R6: odd field selects external data memory on the same pair
        issue(8'hF2, 8'h07);
        idle(16);

        // R5: wrap from 0000h
        poke(4'h4, 8'h00);
        poke(4'h5, 8'h00);
        poke(4'h9, 8'hA5);
        issue(8'hF2, 8'h95);
        idle(16);
        chk(rf[4] == 8'hFF && rf[5] == 8'hFF, "R5 wrap", {rf[4], rf[5]}, 16'hFFFF);

        // R2: a different opcode is dropped
        issue(8'hF3, 8'h06);
        idle(16);
        chk(rf[6] == 8'h2F && rf[7] == 8'hFE, "R2 pair untouched", {rf[6], rf[7]}, 16'h2FFE);

        // R10: start while busy is dropped
        poke(4'h2, 8'h12);
        poke(4'h3, 8'h34);
        poke(4'h1, 8'h5A);
        issue(8'hF2, 8'h12);
        idle(4);
        issue(8'hF2, 8'h07);
        idle(20);
        chk(rf[6] == 8'h2F && rf[7] == 8'hFE, "R10 second start dropped", {rf[6], rf[7]}, 16'h2FFE);
        chk(rf[2] == 8'h12 && rf[3] == 8'h33, "R10 first completed", {rf[2], rf[3]}, 16'h1233);

        // R3: source inside the pair reads the original high byte
        poke(4'hA, 8'h80);
        poke(4'hB, 8'h00);
        issue(8'hF2, 8'hAA);
        idle(16);

        // R9 R11: starts near the end of a run and right after it
        issue(8'hF2, 8'h02);
        idle(11);
        issue(8'hF2, 8'h03);
        idle(13);
        issue(8'hF2, 8'h06);
        idle(18);

        $display("[TB] %0d tests run, %0d failed", tests, fails);
        $finish;
    end

    initial begin
        repeat (200000) @(posedge clk);
        fails++;
        tests++;
        $display("FAIL watchdog actual=%0h expected=%0h", 1, 0);
        $display("[TB] %0d tests run, %0d failed", tests, fails);
        $finish;
    end

endmodule